// File: doc/BRIEF.md
# Decoded Instruction Queue with Prefix Delay

This block is the decode front end of a dual-pipe in-order core, together with its small buffer of decoded instructions. It receives up to two instruction descriptors per cycle. Each descriptor gives a length in bytes, a prefix count and a mask of the prefix kinds present. The block works out how many cycles the older descriptor spends in decode, decides whether the younger one may decode alongside it, and places finished instructions into a four-entry queue. Opcode decoding and execution are outside the block. Each descriptor carries an opaque tag, and the tag is the only thing stored.

Two execution pipes read from the head of the queue. The first pipe takes the oldest entry and the second pipe takes the next one, so each pipe takes at most one entry per cycle. When the queue is empty, an instruction that completes decode appears at the issue outputs in that same cycle. The queue therefore hides decode delays whenever execution runs slower than decode. A flush, raised for instance on a mispredicted branch, discards every queued entry.

Prefix mask bits: bit 0 segment override, bit 1 repeat, bit 2 address-size, bit 3 operand-size, bit 4 two-byte escape.

Top module: `decode_queue`

## Requirements
- R1: The queue never holds more than DEPTH (default 4) decoded instructions, and `out_valid` shows 2'b11 when two or more are available.
- R2: The number of decode cycles is one plus a base cost plus a multi-prefix cost. The base cost is 2 when mask bit 2 or bit 3 is set. Otherwise it is 1 when mask bit 0 or bit 1 is set. Otherwise it is 0. With a base cost of C and a multi-prefix cost of M, `dec_take0` rises in the (C+M+1)-th cycle that the descriptor is presented.
- R3: The multi-prefix cost M is (prefix count − 1) when the count is greater than 1, and 0 otherwise.
- R4: A two-byte escape prefix (mask bit 4) on its own adds no decode cycle.
- R5: The younger descriptor is accepted in the same cycle as the older one (`dec_take1`) only if all of the following hold:
  - the younger descriptor has a prefix count of 0 and a mask of 0;
  - both lengths are at most 7 bytes;
  - the queue has room for two entries.
- R6: An older descriptor that carries an address-size or operand-size prefix always decodes alone, so `dec_take1` stays low.
- R7: When the queue is empty, an instruction that completes decode is shown on `out_valid[0]`/`out_tag0` in that same cycle.
- R8: Issue keeps program order. The first pipe consumes the oldest entry (`pull_u`). The second pipe consumes the next entry (`pull_v`) only in a cycle where the first pipe also consumes one. Otherwise `pull_v` has no effect.
- R9: While `flush` is high, no descriptor is accepted and `out_valid` is 0. In the following cycle the queue is empty.
- R10: Decode does not complete while the registered queue occupancy leaves too little room for the entries it would write.
- R11: After reset the queue is empty, `out_valid` is 0 and the decode counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard queue and in-progress decode |
| d0_valid | input | 1 | Older descriptor present |
| d0_kinds | input | 5 | Older descriptor prefix-kind mask |
| d0_npfx | input | 3 | Older descriptor prefix count |
| d0_len | input | 4 | Older descriptor length in bytes |
| d0_tag | input | 8 | Older descriptor tag |
| d1_valid | input | 1 | Younger descriptor present |
| d1_kinds | input | 5 | Younger descriptor prefix-kind mask |
| d1_npfx | input | 3 | Younger descriptor prefix count |
| d1_len | input | 4 | Younger descriptor length in bytes |
| d1_tag | input | 8 | Younger descriptor tag |
| dec_take0 | output | 1 | Older descriptor finishes decode this cycle |
| dec_take1 | output | 1 | Younger descriptor decodes with it this cycle |
| pull_u | input | 1 | First pipe requests the oldest entry |
| pull_v | input | 1 | Second pipe requests the next entry |
| out_valid | output | 2 | Valid flags of the two oldest available entries |
| out_tag0 | output | 8 | Tag of the oldest available entry |
| out_tag1 | output | 8 | Tag of the second oldest available entry |

## Verification
The bound checker watches, on every cycle, the rules that can be seen at a single edge or across a short window:
- the occupancy limit;
- the conditions under which pairing is allowed;
- the solo rule for size prefixes and the minimum decode wait that follows from it;
- flush blocking and emptying;
- in-order validity of the two issue slots;
- the same-cycle bypass into an empty queue.

The exact decode latency for each prefix combination, the tag order seen by the pipes under changing pull patterns, the recovery after a full queue, and the discarding of queued tags by a flush can only be shown by the bench's scenarios. Those scenarios compare each issued tag against a scoreboard queue.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int PFX_KINDS = 5;
    localparam int PFX_SEG   = 0;
    localparam int PFX_REP   = 1;
    localparam int PFX_ASZ   = 2;
    localparam int PFX_OSZ   = 3;
    localparam int PFX_ESC   = 4;
    localparam int BASE_SIZE = 2;
    localparam int BASE_SEG  = 1;
endpackage

// File: rtl/dq_prefix_cost.sv
module dq_prefix_cost
    import dq_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int COST_W = CNT_W + 1
) (
    input  logic [PFX_KINDS-1:0] kinds,
    input  logic [CNT_W-1:0]     npfx,
    output logic [COST_W-1:0]    cost,
    output logic                 solo
);
    logic [COST_W-1:0] base;
    logic [COST_W-1:0] extra;

    always_comb begin
        solo = kinds[PFX_ASZ] | kinds[PFX_OSZ];
        if (solo) begin
            base = COST_W'(BASE_SIZE);
        end else if (kinds[PFX_SEG] | kinds[PFX_REP]) begin
            base = COST_W'(BASE_SEG);
        end else begin
            base = '0;
        end
        if (npfx > CNT_W'(1)) begin
            extra = COST_W'(npfx) - COST_W'(1);
        end else begin
            extra = '0;
        end
        cost = base + extra;
    end
endmodule

// File: rtl/dq_decode_seq.sv
module dq_decode_seq #(
    parameter int COST_W   = 4,
    parameter int LEN_W    = 4,
    parameter int OCC_W    = 3,
    parameter int PAIR_LEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              d0_valid,
    input  logic [COST_W-1:0] cost0,
    input  logic              solo0,
    input  logic [LEN_W-1:0]  len0,
    input  logic              d1_valid,
    input  logic              bare1,
    input  logic [LEN_W-1:0]  len1,
    input  logic [OCC_W-1:0]  free_slots,
    output logic              take0,
    output logic              take1
);
    typedef struct packed {
        logic [COST_W-1:0] waited;
    } seq_t;

    seq_t st_d, st_q;
    logic room1, room2, short0, short1;

    always_comb begin
        st_d   = st_q;
        room1  = free_slots >= OCC_W'(1);
        room2  = free_slots >= OCC_W'(2);
        short0 = len0 <= LEN_W'(PAIR_LEN);
        short1 = len1 <= LEN_W'(PAIR_LEN);
        take0  = d0_valid && !flush && (st_q.waited == cost0) && room1;
        take1  = take0 && d1_valid && bare1 && !solo0 && short0 && short1 && room2;
        if (flush || !d0_valid || take0) begin
            st_d.waited = '0;
        end else if (st_q.waited < cost0) begin
            st_d.waited = st_q.waited + COST_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dq_issue_buf.sv
module dq_issue_buf #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             new0,
    input  logic             new1,
    input  logic [TAG_W-1:0] tag0_in,
    input  logic [TAG_W-1:0] tag1_in,
    input  logic             pull_u,
    input  logic             pull_v,
    output logic [1:0]       out_valid,
    output logic [TAG_W-1:0] out_tag0,
    output logic [TAG_W-1:0] out_tag1,
    output logic [OCC_W-1:0] occ
);
    localparam int VIEW = DEPTH + 2;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] slot;
        logic [OCC_W-1:0]            count;
    } buf_t;

    buf_t st_d, st_q;
    logic [VIEW-1:0][TAG_W-1:0] view;
    int unsigned avail;
    int unsigned pops;
    logic fire_u, fire_v;

    always_comb begin
        st_d  = st_q;
        avail = int'(st_q.count) + (new0 ? 1 : 0) + (new1 ? 1 : 0);
        for (int i = 0; i < VIEW; i++) begin
            view[i] = (i == int'(st_q.count)) ? tag0_in : tag1_in;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(st_q.count)) begin
                view[i] = st_q.slot[i];
            end
        end
        out_valid[0] = !flush && (avail >= 1);
        out_valid[1] = !flush && (avail >= 2);
        out_tag0     = view[0];
        out_tag1     = view[1];
        fire_u       = pull_u && out_valid[0];
        fire_v       = pull_v && out_valid[1] && fire_u;
        pops         = (fire_u ? 1 : 0) + (fire_v ? 1 : 0);
        for (int i = 0; i < DEPTH; i++) begin
            case (pops)
                0:       st_d.slot[i] = view[i];
                1:       st_d.slot[i] = view[i+1];
                default: st_d.slot[i] = view[i+2];
            endcase
        end
        if (flush) begin
            st_d.count = '0;
        end else begin
            st_d.count = OCC_W'(avail - pops);
        end
    end

    assign occ = st_q.count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/decode_queue.sv
module decode_queue
    import dq_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int TAG_W    = 8,
    parameter int LEN_W    = 4,
    parameter int CNT_W    = 3,
    parameter int PAIR_LEN = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 d0_valid,
    input  logic [PFX_KINDS-1:0] d0_kinds,
    input  logic [CNT_W-1:0]     d0_npfx,
    input  logic [LEN_W-1:0]     d0_len,
    input  logic [TAG_W-1:0]     d0_tag,
    input  logic                 d1_valid,
    input  logic [PFX_KINDS-1:0] d1_kinds,
    input  logic [CNT_W-1:0]     d1_npfx,
    input  logic [LEN_W-1:0]     d1_len,
    input  logic [TAG_W-1:0]     d1_tag,
    output logic                 dec_take0,
    output logic                 dec_take1,
    input  logic                 pull_u,
    input  logic                 pull_v,
    output logic [1:0]           out_valid,
    output logic [TAG_W-1:0]     out_tag0,
    output logic [TAG_W-1:0]     out_tag1
);
    localparam int OCC_W  = $clog2(DEPTH + 1);
    localparam int COST_W = CNT_W + 1;

    logic [COST_W-1:0] cost0;
    logic              solo0;
    logic              bare1;
    logic [OCC_W-1:0]  buf_occ;
    logic [OCC_W-1:0]  free_slots;

    assign bare1      = (d1_npfx == '0) && (d1_kinds == '0);
    assign free_slots = OCC_W'(DEPTH) - buf_occ;

    dq_prefix_cost #(.CNT_W(CNT_W), .COST_W(COST_W)) u_cost (
        .kinds (d0_kinds),
        .npfx  (d0_npfx),
        .cost  (cost0),
        .solo  (solo0)
    );

    dq_decode_seq #(
        .COST_W(COST_W), .LEN_W(LEN_W), .OCC_W(OCC_W), .PAIR_LEN(PAIR_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .d0_valid   (d0_valid),
        .cost0      (cost0),
        .solo0      (solo0),
        .len0       (d0_len),
        .d1_valid   (d1_valid),
        .bare1      (bare1),
        .len1       (d1_len),
        .free_slots (free_slots),
        .take0      (dec_take0),
        .take1      (dec_take1)
    );

    dq_issue_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OCC_W(OCC_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .new0      (dec_take0),
        .new1      (dec_take1),
        .tag0_in   (d0_tag),
        .tag1_in   (d1_tag),
        .pull_u    (pull_u),
        .pull_v    (pull_v),
        .out_valid (out_valid),
        .out_tag0  (out_tag0),
        .out_tag1  (out_tag1),
        .occ       (buf_occ)
    );
endmodule

// File: rtl/dq_queue_chk.sv
module dq_queue_chk
    import dq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int LEN_W = 4,
    parameter int CNT_W = 3,
    parameter int OCC_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 d0_valid,
    input logic [PFX_KINDS-1:0] d0_kinds,
    input logic [LEN_W-1:0]     d0_len,
    input logic [TAG_W-1:0]     d0_tag,
    input logic [PFX_KINDS-1:0] d1_kinds,
    input logic [CNT_W-1:0]     d1_npfx,
    input logic [LEN_W-1:0]     d1_len,
    input logic                 dec_take0,
    input logic                 dec_take1,
    input logic [1:0]           out_valid,
    input logic [TAG_W-1:0]     out_tag0,
    input logic [OCC_W-1:0]     buf_occ
);
    p_occ_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        buf_occ <= OCC_W'(DEPTH));

    p_wide_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_take0 && (d0_kinds[PFX_ASZ] || d0_kinds[PFX_OSZ]))
        |-> ($past(d0_valid) && $past(d0_valid, 2)));

    p_pair_terms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_take1 |-> (dec_take0 && d1_kinds == '0 && d1_npfx == '0
                       && d0_len <= LEN_W'(7) && d1_len <= LEN_W'(7)));

    p_solo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_kinds[PFX_ASZ] || d0_kinds[PFX_OSZ]) |-> !dec_take1);

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_occ == '0 && dec_take0) |-> (out_valid[0] && out_tag0 == d0_tag));

    p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] |-> out_valid[0]);

    p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!dec_take0 && out_valid == 2'b00));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (buf_occ == '0));

    p_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_occ == OCC_W'(DEPTH)) |-> !dec_take0);
endmodule

bind decode_queue dq_queue_chk #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .d0_valid  (d0_valid),
    .d0_kinds  (d0_kinds),
    .d0_len    (d0_len),
    .d0_tag    (d0_tag),
    .d1_kinds  (d1_kinds),
    .d1_npfx   (d1_npfx),
    .d1_len    (d1_len),
    .dec_take0 (dec_take0),
    .dec_take1 (dec_take1),
    .out_valid (out_valid),
    .out_tag0  (out_tag0),
    .buf_occ   (buf_occ)
);

// File: tb/test_decode_queue.sv
`timescale 1ns/1ps
module test_decode_queue;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       d0_valid = 1'b0, d1_valid = 1'b0;
    logic [4:0] d0_kinds = '0, d1_kinds = '0;
    logic [2:0] d0_npfx = '0, d1_npfx = '0;
    logic [3:0] d0_len = '0, d1_len = '0;
    logic [7:0] d0_tag = '0, d1_tag = '0;
    logic       dec_take0, dec_take1;
    logic       pull_u = 1'b0, pull_v = 1'b0;
    logic [1:0] out_valid;
    logic [7:0] out_tag0, out_tag1;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] exp_q[$];

    always #HALF clk = ~clk;

    decode_queue i_decode_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .d0_valid(d0_valid), .d0_kinds(d0_kinds), .d0_npfx(d0_npfx),
        .d0_len(d0_len), .d0_tag(d0_tag),
        .d1_valid(d1_valid), .d1_kinds(d1_kinds), .d1_npfx(d1_npfx),
        .d1_len(d1_len), .d1_tag(d1_tag),
        .dec_take0(dec_take0), .dec_take1(dec_take1),
        .pull_u(pull_u), .pull_v(pull_v),
        .out_valid(out_valid), .out_tag0(out_tag0), .out_tag1(out_tag1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard for every entry a pipe consumes (R8 rule).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                bit fu, fv;
                fu = pull_u && out_valid[0];
                fv = pull_v && out_valid[1] && fu;
                if (fu) begin
                    check(exp_q.size() > 0, "R8 u issue with empty scoreboard", exp_q.size(), 1);
                    if (exp_q.size() > 0) begin
                        check(out_tag0 == exp_q[0], "R8 u tag order", out_tag0, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                end
                if (fv) begin
                    check(exp_q.size() > 0, "R8 v issue with empty scoreboard", exp_q.size(), 1);
                    if (exp_q.size() > 0) begin
                        check(out_tag1 == exp_q[0], "R8 v tag order", out_tag1, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    // Driver: present descriptors at a negedge, measure decode cycles, push expected tags.
    task automatic send(input logic [7:0] t0, input logic [4:0] k0, input logic [2:0] n0,
                        input logic [3:0] l0, input bit has1, input logic [7:0] t1,
                        input logic [4:0] k1, input logic [2:0] n1, input logic [3:0] l1,
                        input int ecost, input bit epair, input string req);
        int c = 0;
        d0_valid = 1'b1; d0_tag = t0; d0_kinds = k0; d0_npfx = n0; d0_len = l0;
        d1_valid = has1; d1_tag = t1; d1_kinds = k1; d1_npfx = n1; d1_len = l1;
        #1;
        while (!dec_take0 && c < 20) begin
            @(negedge clk);
            #1;
            c++;
        end
        check(c == ecost, {req, " decode wait"}, c, ecost);
        check(dec_take1 == epair, {req, " pairing"}, dec_take1, epair);
        if (dec_take0) exp_q.push_back(t0);
        if (dec_take1) exp_q.push_back(t1);
        @(negedge clk);
        d0_valid = 1'b0;
        d1_valid = 1'b0;
    endtask

    task automatic drain();
        pull_u = 1'b1; pull_v = 1'b1;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 drain scoreboard", exp_q.size(), 0);
        check(out_valid == 2'b00, "R8 drained out_valid", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        check(out_valid == 2'b00, "R11 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 2'b00 && dec_take0 == 1'b0, "R11 idle after reset", out_valid, 0);
        pull_u = 1'b1; pull_v = 1'b1;
        @(negedge clk);

        // R2/R5: plain pair, no prefixes
        send(8'h01, 5'h00, 3'd0, 4'd3, 1, 8'h02, 5'h00, 3'd0, 4'd2, 0, 1, "R5 plain pair");
        // R2: segment, repeat single prefix
        send(8'h03, 5'h01, 3'd1, 4'd4, 1, 8'h04, 5'h00, 3'd0, 4'd1, 1, 1, "R2 segment");
        send(8'h05, 5'h02, 3'd1, 4'd2, 0, 8'h00, 5'h00, 3'd0, 4'd1, 1, 0, "R2 repeat");
        // R6: size prefixes decode alone with cost 2
        send(8'h06, 5'h04, 3'd1, 4'd5, 1, 8'h07, 5'h00, 3'd0, 4'd1, 2, 0, "R6 address-size");
        send(8'h08, 5'h08, 3'd1, 4'd5, 1, 8'h09, 5'h00, 3'd0, 4'd1, 2, 0, "R6 operand-size");
        // R3: multi-prefix extras
        send(8'h0A, 5'h03, 3'd2, 4'd5, 1, 8'h0B, 5'h00, 3'd0, 4'd1, 2, 1, "R3 seg+rep");
        send(8'h0C, 5'h09, 3'd2, 4'd6, 0, 8'h00, 5'h00, 3'd0, 4'd1, 3, 0, "R3 opsize+seg");
        send(8'h0D, 5'h01, 3'd3, 4'd6, 0, 8'h00, 5'h00, 3'd0, 4'd1, 3, 0, "R3 three segment");
        // R4: escape alone free, escape plus segment
        send(8'h0E, 5'h10, 3'd1, 4'd3, 1, 8'h0F, 5'h00, 3'd0, 4'd2, 0, 1, "R4 escape only");
        send(8'h10, 5'h11, 3'd2, 4'd4, 0, 8'h00, 5'h00, 3'd0, 4'd1, 2, 0, "R4 escape+segment");
        // R5: pairing blocked by length or younger prefix
        send(8'h11, 5'h00, 3'd0, 4'd8, 1, 8'h12, 5'h00, 3'd0, 4'd2, 0, 0, "R5 older len 8");
        send(8'h13, 5'h00, 3'd0, 4'd7, 1, 8'h14, 5'h00, 3'd0, 4'd8, 0, 0, "R5 younger len 8");
        send(8'h15, 5'h00, 3'd0, 4'd7, 1, 8'h16, 5'h10, 3'd1, 4'd2, 0, 0, "R5 younger escape");
        send(8'h17, 5'h00, 3'd0, 4'd7, 1, 8'h18, 5'h00, 3'd0, 4'd7, 0, 1, "R5 both len 7");
        drain();

        // R7: bypass into empty queue with pipes idle
        pull_u = 1'b0; pull_v = 1'b0;
        d0_valid = 1'b1; d0_tag = 8'h20; d0_kinds = '0; d0_npfx = '0; d0_len = 4'd2;
        #1;
        check(dec_take0 && out_valid[0] && out_tag0 == 8'h20, "R7 same-cycle bypass", out_tag0, 8'h20);
        exp_q.push_back(8'h20);
        @(negedge clk);
        d0_valid = 1'b0;

        // R1/R10: fill to four, fifth must wait
        send(8'h41, 5'h00, 3'd0, 4'd2, 0, 8'h00, 5'h00, 3'd0, 4'd1, 0, 0, "R1 fill 2");
        send(8'h42, 5'h00, 3'd0, 4'd2, 1, 8'h43, 5'h00, 3'd0, 4'd1, 0, 1, "R1 fill 3-4");
        #1;
        check(out_valid == 2'b11, "R1 two heads valid", out_valid, 3);
        @(negedge clk);
        d0_valid = 1'b1; d0_tag = 8'h44; d0_kinds = '0; d0_npfx = '0; d0_len = 4'd2;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!dec_take0, "R10 full queue blocks decode", dec_take0, 0);
            @(negedge clk);
        end
        // R8: second pipe alone takes nothing
        pull_v = 1'b1;
        @(negedge clk);
        pull_v = 1'b0;
        #1;
        check(out_tag0 == 8'h20, "R8 pull_v alone no effect", out_tag0, 8'h20);
        check(!dec_take0, "R10 still full", dec_take0, 0);
        @(negedge clk);
        pull_u = 1'b1;
        begin
            int c = 0;
            #1;
            while (!dec_take0 && c < 6) begin
                @(negedge clk);
                #1;
                c++;
            end
            check(c == 1, "R10 decode resumes one cycle after a pop", c, 1);
            if (dec_take0) exp_q.push_back(8'h44);
        end
        @(negedge clk);
        d0_valid = 1'b0;
        drain();

        // R9: flush discards queued entries
        pull_u = 1'b0; pull_v = 1'b0;
        send(8'h50, 5'h00, 3'd0, 4'd2, 1, 8'h51, 5'h00, 3'd0, 4'd2, 0, 1, "R9 preload");
        flush = 1'b1;
        d0_valid = 1'b1; d0_tag = 8'h52; d0_kinds = '0; d0_npfx = '0; d0_len = 4'd2;
        #1;
        check(!dec_take0, "R9 no accept during flush", dec_take0, 0);
        check(out_valid == 2'b00, "R9 outputs idle during flush", out_valid, 0);
        @(negedge clk);
        flush = 1'b0;
        d0_valid = 1'b0;
        exp_q.delete();
        #1;
        check(out_valid == 2'b00, "R9 queue empty after flush", out_valid, 0);
        @(negedge clk);
        pull_u = 1'b1; pull_v = 1'b1;
        send(8'h53, 5'h00, 3'd0, 4'd2, 0, 8'h00, 5'h00, 3'd0, 4'd1, 0, 0, "R9 restart");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule